// File: doc/BRIEF.md
# Table-Interpolated Sine/Cosine Generator

This block turns an unsigned phase word, taken as a fraction of one full turn, into a signed sine sample and a signed cosine sample. It accepts a new phase on every clock cycle. Each pair of results appears after a fixed number of cycles. Inside, a quarter-wave sine table is read at two mirrored addresses in the same cycle, which gives a coarse sine and a coarse cosine for the first quadrant. A Taylor correction then refines both values. The phase distance in radians used by the correction is formed with shifts and adds. The refined values are rounded, then rotated into the requested quadrant by swapping and negating.

The parameter `ORDER` selects the correction. Order 1 uses two multiply-accumulates and a 6-cycle pipeline. Order 2 uses four multiply-accumulates and a 9-cycle pipeline. The table is computed when the design elaborates. Its amplitude is set so that rounded outputs stay inside the signed range.

Top module: `sincos_gen`

## Requirements
- R1: A phase presented with `in_valid` high in cycle n gives `out_valid` high in cycle n+LAT, where LAT is 9 for ORDER=2 and 6 for ORDER=1. Every accepted phase gives exactly one result. Results keep input order, and phases may arrive on back-to-back cycles.
- R2: The phase is an unsigned fraction of a full turn. With the default widths: bits 19:18 select the quadrant, bits 17:8 select the table point, and bits 7:0 are the interpolation fraction. Phase p stands for angle 2·pi·p/2^20.
- R3: Each output lies within 1 LSB of A·sin(angle) and A·cos(angle), where A = 2^(OUT_W-1) − 1.5 (131070.5 for 18-bit outputs).
- R4: cos_out for phase p equals exactly sin_out for phase p + 2^18 (modulo 2^20).
- R5: sin_out for phase p equals exactly the negated sin_out for phase p + 2^19 (modulo 2^20).
- R6: No output ever takes the most negative code. Magnitudes stay at or below 2^(OUT_W-1) − 1.
- R7: While `out_valid` is low, `sin_out` and `cos_out` hold their last values. `in_phase` has no effect while `in_valid` is low.
- R8: While `rst_n` is low, `out_valid` is low. After release, it stays low until a sample accepted after the release reaches the output. Release passes through a two-flop synchronizer.
- R9: The four axis phases give exact codes: 0 gives (0, 131071), 2^18 gives (131071, 0), 2^19 gives (0, −131071), and 3·2^18 gives (−131071, 0), written as (sin, cos).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Phase word is valid this cycle |
| in_phase | input | PHASE_W | Unsigned phase, fraction of a full turn |
| out_valid | output | 1 | Sine and cosine outputs are valid this cycle |
| sin_out | output | OUT_W | Signed sine sample |
| cos_out | output | OUT_W | Signed cosine sample |

## Verification
The pipeline can accept a new phase in the same cycle that it delivers the result of an earlier one. A gap in the input stream can also sit between the two. To provoke both cases, the bench streams groups of three phases spaced a quarter turn and a half turn apart, back to back, with an idle cycle every seventh phase. Both correction orders run side by side. A shifted, lost or repeated result would break the exact identities between neighbours in a group, or break the count and order of valid outputs. Each result is also compared with a real-valued model to within one LSB.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  typedef enum logic [1:0] {QD_0, QD_1, QD_2, QD_3} quad_e;

  localparam real PI_R = 3.14159265358979323846;

  // pi scaled by 2**sh, rounded to the nearest integer
  function automatic int pi_fixed(input int sh);
    return int'(PI_R * (2.0 ** sh));
  endfunction

endpackage

// File: rtl/sincos_qrom.sv
module sincos_qrom
  import sincos_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TW    = 22,
  parameter int AMP   = 2097128
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic [IDX_W-1:0]     idx,
  output logic signed [TW-1:0] sin_b,
  output logic signed [TW-1:0] cos_b
);
  localparam int M = 1 << IDX_W;

  logic signed [TW-1:0] tab [0:M];

  for (genvar g = 0; g <= M; g++) begin : g_tab
    localparam int V = $rtoi($floor(real'(AMP) * $sin(real'(g) * PI_R / (2.0 * M)) + 0.5));
    assign tab[g] = TW'(V);
  end

  logic [IDX_W:0]       mir;
  logic signed [TW-1:0] sin_d, cos_d;

  always_comb begin
    mir   = (IDX_W+1)'(M) - {1'b0, idx};
    sin_d = tab[{1'b0, idx}];
    cos_d = tab[mir];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sin_b <= sin_d;
      cos_b <= cos_d;
    end
  end
endmodule

// File: rtl/sincos_refine.sv
module sincos_refine #(
  parameter int ORDER = 2,
  parameter int TW    = 22,
  parameter int DW    = 21,
  parameter int XW    = 24,
  parameter int SH    = 29,
  parameter int NS    = 5
) (
  input  logic                 clk,
  input  logic [NS-1:0]        en,
  input  logic signed [DW-1:0] d_in,
  input  logic signed [TW-1:0] sb,
  input  logic signed [TW-1:0] cb,
  output logic signed [XW-1:0] s_out,
  output logic signed [XW-1:0] c_out
);
  localparam int PW = DW + XW + 1;

  if (ORDER == 1) begin : g_o1
    logic signed [PW-1:0] ps_d, pc_d, ps_q, pc_q;
    logic signed [TW-1:0] sb_q, cb_q;
    logic signed [XW-1:0] s_d, c_d;

    always_comb begin
      ps_d = PW'(d_in) * PW'(cb);
      pc_d = PW'(d_in) * PW'(sb);
    end
    always_ff @(posedge clk) begin
      if (en[0]) begin
        ps_q <= ps_d;
        pc_q <= pc_d;
        sb_q <= sb;
        cb_q <= cb;
      end
    end
    always_comb begin
      s_d = XW'(sb_q) + XW'(ps_q >>> SH);
      c_d = XW'(cb_q) - XW'(pc_q >>> SH);
    end
    always_ff @(posedge clk) begin
      if (en[1]) begin
        s_out <= s_d;
        c_out <= c_d;
      end
    end
  end else begin : g_o2
    logic signed [PW-1:0] m1_d, m2_d, m1_q, m2_q;
    logic signed [PW-1:0] n1_d, n2_d, n1_q, n2_q, n1_r, n2_r;
    logic signed [XW-1:0] a_d, b_d, a_q, b_q, s_d, c_d;
    logic signed [DW-1:0] d3, d4;
    logic signed [TW-1:0] sb3, cb3, sb4, cb4, sb5, cb5, sb6, cb6;

    always_comb begin
      m1_d = PW'(d_in) * PW'(sb);
      m2_d = PW'(d_in) * PW'(cb);
      a_d  = XW'(cb3) - XW'(m1_q >>> (SH + 1));
      b_d  = XW'(sb3) + XW'(m2_q >>> (SH + 1));
      n1_d = PW'(d4) * PW'(a_q);
      n2_d = PW'(d4) * PW'(b_q);
      s_d  = XW'(sb6) + XW'(n1_r >>> SH);
      c_d  = XW'(cb6) - XW'(n2_r >>> SH);
    end

    always_ff @(posedge clk) begin
      if (en[0]) begin
        m1_q <= m1_d; m2_q <= m2_d; d3 <= d_in; sb3 <= sb; cb3 <= cb;
      end
      if (en[1]) begin
        a_q <= a_d; b_q <= b_d; d4 <= d3; sb4 <= sb3; cb4 <= cb3;
      end
      if (en[2]) begin
        n1_q <= n1_d; n2_q <= n2_d; sb5 <= sb4; cb5 <= cb4;
      end
      if (en[3]) begin
        n1_r <= n1_q; n2_r <= n2_q; sb6 <= sb5; cb6 <= cb5;
      end
      if (en[4]) begin
        s_out <= s_d; c_out <= c_d;
      end
    end
  end
endmodule

// File: rtl/sincos_fold.sv
module sincos_fold
  import sincos_pkg::*;
#(
  parameter int XW    = 24,
  parameter int OUT_W = 18,
  parameter int GUARD = 4
) (
  input  logic                    clk,
  input  logic                    en_r,
  input  logic                    en_f,
  input  quad_e                   quad,
  input  logic signed [XW-1:0]    s_in,
  input  logic signed [XW-1:0]    c_in,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out
);
  localparam int HALF = 1 << (GUARD - 1);

  logic signed [OUT_W-1:0] sr_d, cr_d, sr_q, cr_q, so_d, co_d;

  always_comb begin
    sr_d = OUT_W'((s_in + XW'(HALF)) >>> GUARD);
    cr_d = OUT_W'((c_in + XW'(HALF)) >>> GUARD);
  end

  always_ff @(posedge clk) begin
    if (en_r) begin
      sr_q <= sr_d;
      cr_q <= cr_d;
    end
  end

  always_comb begin
    case (quad)
      QD_0:    begin so_d = sr_q;  co_d = cr_q;  end
      QD_1:    begin so_d = cr_q;  co_d = -sr_q; end
      QD_2:    begin so_d = -sr_q; co_d = -cr_q; end
      default: begin so_d = -cr_q; co_d = sr_q;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (en_f) begin
      sin_out <= so_d;
      cos_out <= co_d;
    end
  end
endmodule

// File: rtl/sincos_gen.sv
module sincos_gen
  import sincos_pkg::*;
#(
  parameter int PHASE_W = 20,
  parameter int OUT_W   = 18,
  parameter int IDX_W   = 10,
  parameter int GUARD   = 4,
  parameter int PI_SH   = 10,
  parameter int ORDER   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out
);
  localparam int FRAC_W = PHASE_W - 2 - IDX_W;
  localparam int TW     = OUT_W + GUARD;
  localparam int XW     = TW + 2;
  localparam int DW     = FRAC_W + PI_SH + 3;
  localparam int SH     = FRAC_W + IDX_W + 1 + PI_SH;
  localparam int NS     = (ORDER == 1) ? 2 : 5;
  localparam int LAT    = NS + 4;
  localparam int AMP    = ((1 << (OUT_W - 1)) - 1) * (1 << GUARD) - (1 << (GUARD - 1));
  localparam int PI_K   = pi_fixed(PI_SH);

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  // valid chain, one bit per stage
  logic [LAT-1:0] vld_d, vld_q;
  always_comb vld_d = {vld_q[LAT-2:0], in_valid};
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vld_q <= '0;
    else          vld_q <= vld_d;
  end
  assign out_valid = vld_q[LAT-1];

  // stage 1: capture phase
  logic [PHASE_W-1:0] ph_q;
  always_ff @(posedge clk) begin
    if (in_valid) ph_q <= in_phase;
  end

  // stage 2: residue in radians via shift-add of pi, table read
  logic signed [DW-1:0] d_d, d_q;
  always_comb begin
    d_d = '0;
    for (int b = 0; b < PI_SH + 2; b++) begin
      if (PI_K[b]) d_d = d_d + (DW'(ph_q[FRAC_W-1:0]) << b);
    end
  end
  always_ff @(posedge clk) begin
    if (vld_q[0]) d_q <= d_d;
  end

  logic signed [TW-1:0] sb, cb;
  sincos_qrom #(.IDX_W(IDX_W), .TW(TW), .AMP(AMP)) u_rom (
    .clk(clk), .en(vld_q[0]), .idx(ph_q[FRAC_W +: IDX_W]),
    .sin_b(sb), .cos_b(cb)
  );

  // quadrant travels alongside the data
  quad_e q_pipe [0:LAT-3];
  always_ff @(posedge clk) begin
    if (vld_q[0]) q_pipe[0] <= quad_e'(ph_q[PHASE_W-1 -: 2]);
    for (int s = 1; s < LAT - 2; s++) begin
      if (vld_q[s]) q_pipe[s] <= q_pipe[s-1];
    end
  end

  // stages 3 .. NS+2: Taylor correction
  logic signed [XW-1:0] s_ref, c_ref;
  sincos_refine #(.ORDER(ORDER), .TW(TW), .DW(DW), .XW(XW), .SH(SH), .NS(NS)) u_ref (
    .clk(clk), .en(vld_q[NS:1]), .d_in(d_q), .sb(sb), .cb(cb),
    .s_out(s_ref), .c_out(c_ref)
  );

  // last two stages: round, then quadrant fold
  sincos_fold #(.XW(XW), .OUT_W(OUT_W), .GUARD(GUARD)) u_fold (
    .clk(clk), .en_r(vld_q[LAT-3]), .en_f(vld_q[LAT-2]), .quad(q_pipe[LAT-3]),
    .s_in(s_ref), .c_in(c_ref), .sin_out(sin_out), .cos_out(cos_out)
  );
endmodule

// File: rtl/sincos_gen_chk.sv
module sincos_gen_chk #(
  parameter int PHASE_W = 20,
  parameter int OUT_W   = 18,
  parameter int LAT     = 9
) (
  input logic                    clk,
  input logic                    rst_q_n,
  input logic                    in_valid,
  input logic [PHASE_W-1:0]      in_phase,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] sin_out,
  input logic signed [OUT_W-1:0] cos_out
);
  localparam logic signed [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  logic [4:0] warm;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)         warm <= '0;
    else if (warm != 5'd31) warm <= warm + 5'd1;
  end

  // R1: valid emerges exactly LAT cycles after it entered
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (warm >= 5'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

  // R6: most negative code never produced
  p_no_min_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> ((sin_out != MINV) && (cos_out != MINV)));

  // R7: outputs hold while nothing valid leaves
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((warm >= 5'd1) && !out_valid) |-> ($stable(sin_out) && $stable(cos_out)));

  // R9: zero phase gives exact axis codes
  p_axis_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((warm >= 5'(LAT)) && out_valid && $past(in_valid, LAT) && ($past(in_phase, LAT) == '0))
      |-> ((sin_out == '0) && (cos_out == MAXV)));

  // R8: nothing valid while held in reset
  always @(posedge clk) begin
    if (!rst_q_n) p_idle_r8: assert (!out_valid);
  end
endmodule

bind sincos_gen sincos_gen_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .in_valid(in_valid), .in_phase(in_phase),
  .out_valid(out_valid), .sin_out(sin_out), .cos_out(cos_out)
);

// File: tb/sincos_gen_test.sv
`timescale 1ns/1ps
module sincos_gen_test;
  localparam int  QTR  = 1 << 18;
  localparam int  HLF  = 1 << 19;
  localparam int  MAXV = 131071;
  localparam real AMP  = 131070.5;
  localparam real PI   = 3.14159265358979323846;
  localparam int  NCAP = 2048;

  typedef struct packed {
    logic [19:0]        ph;
    logic               ex;
    logic signed [17:0] es;
    logic signed [17:0] ec;
  } vec_t;

  localparam vec_t VECS [0:13] = '{
    '{20'h00000, 1'b1, 18'sd0,      18'sd131071},
    '{20'h40000, 1'b1, 18'sd131071, 18'sd0},
    '{20'h80000, 1'b1, 18'sd0,      -18'sd131071},
    '{20'hC0000, 1'b1, -18'sd131071, 18'sd0},
    '{20'h00001, 1'b0, 18'sd0, 18'sd0},
    '{20'h000FF, 1'b0, 18'sd0, 18'sd0},
    '{20'h00100, 1'b0, 18'sd0, 18'sd0},
    '{20'h3FFFF, 1'b0, 18'sd0, 18'sd0},
    '{20'h40001, 1'b0, 18'sd0, 18'sd0},
    '{20'h7FF80, 1'b0, 18'sd0, 18'sd0},
    '{20'h9ABCD, 1'b0, 18'sd0, 18'sd0},
    '{20'hC0123, 1'b0, 18'sd0, 18'sd0},
    '{20'hFFFFF, 1'b0, 18'sd0, 18'sd0},
    '{20'h2AAAA, 1'b0, 18'sd0, 18'sd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [19:0] in_phase;
  logic ov2, ov1;
  logic signed [17:0] s2, c2, s1, c1;

  always #2 clk = ~clk;

  sincos_gen #(.ORDER(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(ov2), .sin_out(s2), .cos_out(c2)
  );
  sincos_gen #(.ORDER(1)) uut_o1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(ov1), .sin_out(s1), .cos_out(c1)
  );

  int total = 0;
  int bad = 0;
  int n2 = 0;
  int n1 = 0;
  logic [19:0]        ph_list [0:NCAP-1];
  logic signed [17:0] cs2 [0:NCAP-1];
  logic signed [17:0] cc2 [0:NCAP-1];
  logic signed [17:0] cs1 [0:NCAP-1];
  logic signed [17:0] cc1 [0:NCAP-1];

  always @(negedge clk) begin
    if (ov2 === 1'b1 && n2 < NCAP) begin cs2[n2] = s2; cc2[n2] = c2; n2++; end
    if (ov1 === 1'b1 && n1 < NCAP) begin cs1[n1] = s1; cc1[n1] = c1; n1++; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_acc(input string req, input logic [19:0] ph,
                         input logic signed [17:0] s, input logic signed [17:0] c);
    real ang, es, ec;
    ang = 2.0 * PI * real'(ph) / 1048576.0;
    es  = AMP * $sin(ang);
    ec  = AMP * $cos(ang);
    chk((real'(s) - es <= 1.0) && (real'(s) - es >= -1.0), {req, " sin"}, s, $rtoi(es));
    chk((real'(c) - ec <= 1.0) && (real'(c) - ec >= -1.0), {req, " cos"}, c, $rtoi(ec));
  endtask

  task automatic run(input int n, input bit gaps);
    n1 = 0;
    n2 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (gaps && (k % 7 == 3)) begin
        in_valid = 1'b0;
        in_phase = ~ph_list[k];
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_phase = ph_list[k];
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat2, lat1, cnt2, cnt1;
    logic signed [17:0] hs, hc;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_phase = '0;

    // R8: held in reset, then released with nothing sent
    repeat (4) @(negedge clk);
    chk(ov2 == 1'b0 && ov1 == 1'b0, "R8 valid in reset", {ov2, ov1}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ov2 == 1'b0 && ov1 == 1'b0, "R8 valid after release", {ov2, ov1}, 0);

    // R1: single sample latency for both orders
    lat2 = -1; lat1 = -1; cnt2 = 0; cnt1 = 0;
    in_valid = 1'b1;
    in_phase = 20'h2468A;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (k == 1) begin in_valid = 1'b0; in_phase = 20'h55555; end
      if (ov2) begin cnt2++; if (lat2 < 0) lat2 = k; end
      if (ov1) begin cnt1++; if (lat1 < 0) lat1 = k; end
    end
    chk(lat2 == 9, "R1 latency order 2", lat2, 9);
    chk(lat1 == 6, "R1 latency order 1", lat1, 6);
    chk(cnt2 == 1 && cnt1 == 1, "R1 one result per sample", cnt2 * 10 + cnt1, 11);
    chk_acc("R3 single", 20'h2468A, s2, c2);

    // table walk, streamed back to back
    for (int k = 0; k < 14; k++) ph_list[k] = VECS[k].ph;
    run(14, 1'b0);
    chk(n2 == 14 && n1 == 14, "R1 table count", n2 * 100 + n1, 1414);
    for (int k = 0; k < 14; k++) begin
      if (VECS[k].ex) begin
        chk(cs2[k] == VECS[k].es && cc2[k] == VECS[k].ec, "R9 axis order 2",
            {cs2[k], cc2[k]}, {VECS[k].es, VECS[k].ec});
        chk(cs1[k] == VECS[k].es && cc1[k] == VECS[k].ec, "R9 axis order 1",
            {cs1[k], cc1[k]}, {VECS[k].es, VECS[k].ec});
      end
      chk_acc("R2 R3 table o2", VECS[k].ph, cs2[k], cc2[k]);
      chk_acc("R2 R3 table o1", VECS[k].ph, cs1[k], cc1[k]);
    end

    // sweep: groups at p, p+quarter, p+half, with idle gaps
    for (int g = 0; g < 512; g++) begin
      ph_list[3*g]   = 20'(g * 40503 + 77);
      ph_list[3*g+1] = 20'(g * 40503 + 77 + QTR);
      ph_list[3*g+2] = 20'(g * 40503 + 77 + HLF);
    end
    run(1536, 1'b1);
    chk(n2 == 1536 && n1 == 1536, "R1 sweep count", n2, 1536);
    for (int k = 0; k < 1536; k++) begin
      chk_acc("R3 sweep o2", ph_list[k], cs2[k], cc2[k]);
      chk_acc("R3 sweep o1", ph_list[k], cs1[k], cc1[k]);
      chk(cs2[k] != -18'sd131072 && cc2[k] != -18'sd131072 &&
          cs1[k] != -18'sd131072 && cc1[k] != -18'sd131072, "R6 range", cs2[k], MAXV);
    end
    for (int g = 0; g < 512; g++) begin
      chk(cc2[3*g] == cs2[3*g+1], "R4 quarter shift o2", cs2[3*g+1], cc2[3*g]);
      chk(cc1[3*g] == cs1[3*g+1], "R4 quarter shift o1", cs1[3*g+1], cc1[3*g]);
      chk(cs2[3*g] == -cs2[3*g+2], "R5 half shift o2", cs2[3*g+2], -cs2[3*g]);
      chk(cs1[3*g] == -cs1[3*g+2], "R5 half shift o1", cs1[3*g+2], -cs1[3*g]);
    end

    // R7: outputs hold and phase is ignored while valid is low
    hs = cs2[1535];
    hc = cc2[1535];
    for (int k = 0; k < 6; k++) begin
      in_phase = 20'(k * 99991);
      @(negedge clk);
      chk(ov2 == 1'b0 && s2 == hs && c2 == hc, "R7 hold", s2, hs);
      chk(ov1 == 1'b0 && s1 == cs1[1535] && c1 == cc1[1535], "R7 hold o1", s1, cs1[1535]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule